// File: doc/BRIEF.md
# Channel-Partitioned Transmit Sample FIFO

This block is the sample buffer that sits between a register write port and a serial audio transmitter. Software or a bus master writes one sample word per access. The block keeps those words in a fixed store of 256 entries and hands them to the serializer over a valid/ready stream in the same order they were written. The store is shared out evenly among the configured channels. Each channel gets 256 entries when one channel is active, 128 for two, 64 for three or four, and 32 for five to eight. The usable word capacity is therefore the per-channel depth times the channel count.

Occupancy is reported in frames, meaning the number of held words divided by the channel count and rounded down. Overrun and underrun are recorded as sticky flags. An interrupt level asks for more data once the buffer has drained to half of the per-channel depth. A channel-count change is picked up only when the FIFO is cleared. After reset the layout is one channel until the first clear. A channel count of 0 is treated as 1, and a count above the maximum is treated as the maximum.

Stream rules: `out_valid` is high whenever at least one word is held. The head word on `out_data` is consumed on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values. The write side has no back-pressure. A write that finds the store full is dropped and recorded.

Top module: `afifo_tx`

## Requirements
- R1: A sample write (`wr_en`) stores only bits 23:0 of `wr_data`. Bits 31:24 never reach `out_data`.
- R2: When `cfg_half_word` is 1, the stored word is `wr_data[15:0]` placed in bits 23:8, with bits 7:0 zero.
- R3: The number of words accepted after a clear is (256 >> s) * C, where C is the channel count and s is 0 for 1 channel, 1 for 2, 2 for 3 or 4, and 3 for 5 to 8.
- R4: `status[16:8]` reports the held word count divided by C, rounded down. All `status` bits other than 16:8, 4 and 0 read 0.
- R5: A control write (`ctl_wr`) with `ctl_wdata[0]`=1 empties the FIFO, so `out_valid` is 0 on the next cycle. A sample write in that same cycle is dropped. A control write with bit 0 at 0 leaves the contents unchanged.
- R6: `ctl_wdata[20]` is stored on every control write as the interrupt enable. `irq` is high exactly while the enable is 1 and the frame count is at or below half the per-channel depth.
- R7: A sample write while the store is full is discarded, leaves the held words unchanged, and sets `status[4]` (overrun).
- R8: `out_ready` high while the FIFO is empty (outside a clear cycle) sets `status[0]` (underrun).
- R9: Both error flags stay set until a status write (`st_wr`) with a 1 in that flag's bit position. Writing 1 to one flag's bit leaves the other flag unchanged. If a new error event occurs in the same cycle as the write, the flag stays set.
- R10: A change on `cfg_chan` affects capacity and frame counting only after the next FIFO clear.
- R11: Words leave in write order. `out_valid` is high exactly when words are held, and the head word is stable under back-pressure.
- R12: After reset, `status` is 0, `out_valid` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_chan | input | 4 | Requested channel count, 1 to 8, taken at clear |
| cfg_half_word | input | 1 | 1: writes carry a 16-bit sample in the low half |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | 32 | Sample write data |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control data: bit 0 clears, bit 20 enables the interrupt |
| st_wr | input | 1 | Status write strobe (write 1 to clear flags) |
| st_wdata | input | 32 | Status write data: bit 4 overrun, bit 0 underrun |
| status | output | 32 | Frame count in 16:8, overrun in bit 4, underrun in bit 0 |
| irq | output | 1 | Half-empty interrupt level |
| out_valid | output | 1 | Head word available |
| out_data | output | 24 | Head word |
| out_ready | input | 1 | Serializer accepts the head word |

## Verification
The bound checker watches these properties on every cycle: the held word count never exceeds the current capacity, the head word stays stable under back-pressure, a clear leaves the stream empty, a write into a full store raises the overrun flag, a read while empty raises the underrun flag, flags persist until cleared, and the interrupt never rises above the half-depth threshold. The exact capacity for each channel count, the frame arithmetic, the placement of 16-bit and masked 24-bit data, the write-order sequence, and the deferred effect of a channel-count change can only be shown by the bench's scenarios. Those scenarios fill the store to known levels and compare what comes out against values derived from the requirements.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  localparam int CTL_CLR_BIT   = 0;
  localparam int CTL_IRQEN_BIT = 20;
  localparam int ST_UDR_BIT    = 0;
  localparam int ST_OVR_BIT    = 4;
  localparam int ST_LVL_LSB    = 8;
  localparam int ST_LVL_W      = 9;
endpackage

// File: rtl/afifo_chan_cfg.sv
module afifo_chan_cfg #(
  parameter int STORE_DEPTH = 256,
  parameter int MAX_CHAN    = 8,
  parameter int CHAN_W      = 4,
  parameter int LVL_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic              relatch,
  input  logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  depth_ch,
  output logic [LVL_W-1:0]  cap_words,
  output logic [LVL_W-1:0]  half_frames,
  output logic [LVL_W-1:0]  frames
);
  logic [CHAN_W-1:0] active_chan;
  logic [CHAN_W-1:0] chan_sane;

  // Clamp the requested count into 1..MAX_CHAN
  always_comb begin
    if (cfg_chan == '0)
      chan_sane = CHAN_W'(1);
    else if (int'(cfg_chan) > MAX_CHAN)
      chan_sane = CHAN_W'(MAX_CHAN);
    else
      chan_sane = cfg_chan;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      active_chan <= CHAN_W'(1);
    else if (relatch)
      active_chan <= chan_sane;
  end

  function automatic int shift_for(input logic [CHAN_W-1:0] c);
    int s;
    s = 0;
    for (int k = 0; k < CHAN_W; k++)
      if ((1 << k) < int'(c)) s = k + 1;
    return s;
  endfunction

  always_comb begin
    depth_ch    = LVL_W'(STORE_DEPTH >> shift_for(active_chan));
    cap_words   = LVL_W'(int'(depth_ch) * int'(active_chan));
    half_frames = depth_ch >> 1;
  end

  // Frames = held words / channel count, one constant divider per count
  always_comb begin
    frames = level;
    for (int c = 1; c <= MAX_CHAN; c++)
      if (active_chan == CHAN_W'(c))
        frames = level / LVL_W'(c);
  end
endmodule

// File: rtl/afifo_store.sv
module afifo_store #(
  parameter int STORE_DEPTH = 256,
  parameter int DATA_W      = 24,
  parameter int LVL_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [LVL_W-1:0]  level
);
  localparam int PTR_W = $clog2(STORE_DEPTH);

  logic [DATA_W-1:0] mem [STORE_DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;

  always_ff @(posedge clk) begin
    if (push)
      mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
endmodule

// File: rtl/afifo_status.sv
module afifo_status #(
  parameter int LVL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovr_evt,
  input  logic             udr_evt,
  input  logic             ovr_w1c,
  input  logic             udr_w1c,
  input  logic             irq_en_wr,
  input  logic             irq_en_val,
  input  logic [LVL_W-1:0] frames,
  input  logic [LVL_W-1:0] half_frames,
  output logic             ovr_flag,
  output logic             udr_flag,
  output logic             irq
);
  logic irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      udr_flag <= 1'b0;
      irq_en   <= 1'b0;
    end else begin
      // a fresh event outranks a same-cycle clear
      if (ovr_evt)      ovr_flag <= 1'b1;
      else if (ovr_w1c) ovr_flag <= 1'b0;
      if (udr_evt)      udr_flag <= 1'b1;
      else if (udr_w1c) udr_flag <= 1'b0;
      if (irq_en_wr)    irq_en   <= irq_en_val;
    end
  end

  assign irq = irq_en && (frames <= half_frames);
endmodule

// File: rtl/afifo_tx.sv
module afifo_tx
  import afifo_pkg::*;
#(
  parameter int STORE_DEPTH = 256,
  parameter int MAX_CHAN    = 8,
  parameter int DATA_W      = 24,
  parameter int HALF_W      = 16,
  parameter int BUS_W       = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(MAX_CHAN):0]  cfg_chan,
  input  logic                       cfg_half_word,
  input  logic                       wr_en,
  input  logic [BUS_W-1:0]           wr_data,
  input  logic                       ctl_wr,
  input  logic [BUS_W-1:0]           ctl_wdata,
  input  logic                       st_wr,
  input  logic [BUS_W-1:0]           st_wdata,
  output logic [BUS_W-1:0]           status,
  output logic                       irq,
  output logic                       out_valid,
  output logic [DATA_W-1:0]          out_data,
  input  logic                       out_ready
);
  localparam int CHAN_W = $clog2(MAX_CHAN) + 1;
  localparam int LVL_W  = $clog2(STORE_DEPTH) + 1;

  logic              ctl_clr;
  logic              push_req;
  logic              full;
  logic              push;
  logic              pop;
  logic              ovr_evt;
  logic              udr_evt;
  logic [DATA_W-1:0] store_word;
  logic [LVL_W-1:0]  level;
  logic [LVL_W-1:0]  depth_ch;
  logic [LVL_W-1:0]  cap_words;
  logic [LVL_W-1:0]  half_frames;
  logic [LVL_W-1:0]  frames;
  logic              ovr_flag;
  logic              udr_flag;
  logic              unused_bits;

  assign unused_bits = ^{wr_data[BUS_W-1:DATA_W], ctl_wdata, st_wdata, depth_ch};

  assign ctl_clr  = ctl_wr && ctl_wdata[CTL_CLR_BIT];
  assign push_req = wr_en && !ctl_clr;
  assign full     = (level >= cap_words);
  assign push     = push_req && !full;
  assign ovr_evt  = push_req && full;
  assign out_valid = (level != '0);
  assign pop      = out_valid && out_ready && !ctl_clr;
  assign udr_evt  = out_ready && !out_valid && !ctl_clr;

  assign store_word = cfg_half_word
                    ? {wr_data[HALF_W-1:0], {(DATA_W-HALF_W){1'b0}}}
                    : wr_data[DATA_W-1:0];

  afifo_chan_cfg #(
    .STORE_DEPTH(STORE_DEPTH), .MAX_CHAN(MAX_CHAN),
    .CHAN_W(CHAN_W), .LVL_W(LVL_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_chan(cfg_chan), .relatch(ctl_clr),
    .level(level), .depth_ch(depth_ch), .cap_words(cap_words),
    .half_frames(half_frames), .frames(frames)
  );

  afifo_store #(
    .STORE_DEPTH(STORE_DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .flush(ctl_clr), .push(push),
    .push_data(store_word), .pop(pop), .head_data(out_data), .level(level)
  );

  afifo_status #(.LVL_W(LVL_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .ovr_evt(ovr_evt), .udr_evt(udr_evt),
    .ovr_w1c(st_wr && st_wdata[ST_OVR_BIT]),
    .udr_w1c(st_wr && st_wdata[ST_UDR_BIT]),
    .irq_en_wr(ctl_wr), .irq_en_val(ctl_wdata[CTL_IRQEN_BIT]),
    .frames(frames), .half_frames(half_frames),
    .ovr_flag(ovr_flag), .udr_flag(udr_flag), .irq(irq)
  );

  always_comb begin
    status = '0;
    status[ST_LVL_LSB +: ST_LVL_W] = ST_LVL_W'(frames);
    status[ST_OVR_BIT] = ovr_flag;
    status[ST_UDR_BIT] = udr_flag;
  end
endmodule

// File: rtl/afifo_tx_chk.sv
module afifo_tx_chk #(
  parameter int LVL_W  = 9,
  parameter int DATA_W = 24,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              ctl_wr,
  input logic [BUS_W-1:0]  ctl_wdata,
  input logic              st_wr,
  input logic [BUS_W-1:0]  st_wdata,
  input logic [BUS_W-1:0]  status,
  input logic              irq,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ready,
  input logic              full,
  input logic [LVL_W-1:0]  level,
  input logic [LVL_W-1:0]  cap_words,
  input logic [LVL_W-1:0]  half_frames
);
  logic clr;
  assign clr = ctl_wr && ctl_wdata[0];

  AST_LEVEL_IN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> level <= cap_words); // R3

  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data))); // R11

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid); // R5

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !clr) |=> status[4]); // R7

  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !out_valid && !clr) |=> status[0]); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !(st_wr && st_wdata[4])) |=> status[4]); // R9

  AST_UDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !(st_wr && st_wdata[0])) |=> status[0]); // R9

  AST_IRQ_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status[16:8] <= half_frames)); // R6
endmodule

bind afifo_tx afifo_tx_chk #(.LVL_W(LVL_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .st_wr(st_wr), .st_wdata(st_wdata), .status(status), .irq(irq),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
  .full(full), .level(level), .cap_words(cap_words), .half_frames(half_frames)
);

// File: tb/tb_afifo_tx.sv
module tb_afifo_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_chan = 4'd1;
  logic        cfg_half_word = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        st_wr = 1'b0;
  logic [31:0] st_wdata = '0;
  logic [31:0] status;
  logic        irq;
  logic        out_valid;
  logic [23:0] out_data;
  logic        out_ready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  afifo_tx dut (
    .clk(clk), .rst_n(rst_n), .cfg_chan(cfg_chan), .cfg_half_word(cfg_half_word),
    .wr_en(wr_en), .wr_data(wr_data), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .st_wr(st_wr), .st_wdata(st_wdata), .status(status), .irq(irq),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  // {chan[3:0], writes[11:0], frames[8:0], overrun, irq, 5'b0}
  localparam logic [31:0] VEC [10] = '{
    {4'd1, 12'd3,   9'd3,   1'b0, 1'b1, 5'd0},
    {4'd2, 12'd5,   9'd2,   1'b0, 1'b1, 5'd0},
    {4'd3, 12'd200, 9'd64,  1'b1, 1'b0, 5'd0},
    {4'd8, 12'd256, 9'd32,  1'b0, 1'b0, 5'd0},
    {4'd5, 12'd161, 9'd32,  1'b1, 1'b0, 5'd0},
    {4'd4, 12'd130, 9'd32,  1'b0, 1'b1, 5'd0},
    {4'd4, 12'd132, 9'd33,  1'b0, 1'b0, 5'd0},
    {4'd1, 12'd256, 9'd256, 1'b0, 1'b0, 5'd0},
    {4'd7, 12'd230, 9'd32,  1'b1, 1'b0, 5'd0},
    {4'd6, 12'd17,  9'd2,   1'b0, 1'b1, 5'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [31:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic st_clr(input logic [31:0] v);
    @(negedge clk); st_wr = 1'b1; st_wdata = v;
    @(negedge clk); st_wr = 1'b0; st_wdata = '0;
  endtask

  task automatic push_n(input int n);
    @(negedge clk);
    wr_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      wr_data = i;
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic push1(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // checks the head word, then pops it
  task automatic pop_chk(input string req, input logic [23:0] exp);
    @(negedge clk);
    chk(req, {7'd0, out_valid, out_data}, {7'd0, 1'b1, exp});
    out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 status", status, 32'h0);
    chk("R12 valid/irq", {30'd0, out_valid, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R3 capacity, R4 frames, R6 irq, R7 overrun
    foreach (VEC[k]) begin
      @(negedge clk); cfg_chan = VEC[k][31:28];
      st_clr(32'h11);
      ctl(32'h0010_0001);
      push_n(int'(VEC[k][27:16]));
      @(negedge clk);
      chk("R3/R4 frames", {23'd0, status[16:8]}, {23'd0, VEC[k][15:7]});
      chk("R7 overrun", {31'd0, status[4]}, {31'd0, VEC[k][6]});
      chk("R6 irq", {31'd0, irq}, {31'd0, VEC[k][5]});
    end

    // R7: full store, extra write dropped, contents intact
    cfg_chan = 4'd1;
    st_clr(32'h11);
    ctl(32'h0000_0001);
    push_n(256);
    push1(32'h00DE_AD00);
    chk("R7 overrun flag", {31'd0, status[4]}, 32'h1);
    for (int i = 0; i < 256; i++) pop_chk("R7 contents", 24'(i));
    @(negedge clk);
    chk("R7 drained", {31'd0, out_valid}, 32'h0);
    st_clr(32'h11);

    // R1: top byte ignored
    push1(32'hAB12_3456);
    pop_chk("R1 mask", 24'h123456);
    // R2: 16-bit placement
    cfg_half_word = 1'b1;
    push1(32'hFFFF_BEEF);
    pop_chk("R2 half word", 24'hBEEF00);
    cfg_half_word = 1'b0;
    // R11: order and back-pressure stability
    push1(32'h11); push1(32'h22); push1(32'h33);
    repeat (3) @(negedge clk);
    chk("R11 hold", {7'd0, out_valid, out_data}, {7'd0, 1'b1, 24'h11});
    pop_chk("R11 order", 24'h11);
    pop_chk("R11 order", 24'h22);
    pop_chk("R11 order", 24'h33);
    @(negedge clk);
    chk("R11 empty", {31'd0, out_valid}, 32'h0);

    // R8 / R9: underrun, stickiness, per-bit clear, event wins
    st_clr(32'h11);
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    chk("R8 underrun", {31'd0, status[0]}, 32'h1);
    repeat (2) @(negedge clk);
    chk("R9 sticky", {31'd0, status[0]}, 32'h1);
    st_clr(32'h10);
    chk("R9 other bit", {27'd0, status[4:0]}, 32'h1);
    @(negedge clk); out_ready = 1'b1; st_wr = 1'b1; st_wdata = 32'h1;
    @(negedge clk); out_ready = 1'b0; st_wr = 1'b0; st_wdata = '0;
    chk("R9 event wins", {31'd0, status[0]}, 32'h1);
    st_clr(32'h1);
    chk("R9 cleared", {31'd0, status[0]}, 32'h0);

    // R10: channel change deferred to clear
    @(negedge clk); cfg_chan = 4'd2;
    push_n(3);
    @(negedge clk);
    chk("R10 before clear", {23'd0, status[16:8]}, 32'd3);
    ctl(32'h0000_0001);
    chk("R5 clear", {31'd0, out_valid}, 32'h0);
    push_n(3);
    @(negedge clk);
    chk("R10 after clear", {23'd0, status[16:8]}, 32'd1);

    // R6 enable, R5 control write without clear keeps data
    chk("R6 disabled", {31'd0, irq}, 32'h0);
    ctl(32'h0010_0000);
    chk("R6 enabled", {31'd0, irq}, 32'h1);
    chk("R5 no clear", {23'd0, status[16:8]}, 32'd1);
    // R5: write in the clear cycle is dropped
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 32'h1; wr_en = 1'b1; wr_data = 32'h77;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0; wr_en = 1'b0;
    chk("R5 write dropped", {31'd0, out_valid}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule